// File: doc/BRIEF.md
# Quick-Channel Trigger and Completion Controller

This block holds the control state for eight quick DMA channels. Each channel is pointed at one descriptor slot and at one 32-bit word inside that slot. The block watches descriptor writes on a snoop port. A write that lands on a channel's chosen word starts a transfer event for that channel, provided the channel is enabled. The controller then offers pending events one at a time to an external transfer engine through a request/accept handshake.

When the engine reports that a channel has finished, the block looks up the completion code and interrupt-enable flag it captured from that channel's descriptor options word. If the flag is set, it raises the matching bit in a 64-bit pending space. That space is split into a low word and a high word. Software clears bits by writing ones, and a single interrupt line reports whether any pending bit is set.

Software drives all of this through a simple word-addressed register bus. Writes take effect on the clock edge. Reads are combinational on the address.

Top module: `qtc_ctrl`

## Requirements
- R1: After reset, every readable register reads zero, and `req_o` and `irq_o` are low.
- R2: The map register of channel c sits at 0x200 + 4*c. Bits 13:5 hold the slot number and bits 4:2 hold the trigger word index. All other bits read as zero.
- R3: Writing ones to 0x108C enables the matching channels, and writing ones to 0x1088 disables them. Zero bits leave a channel unchanged. The enable mask reads back at 0x108C.
- R4: Descriptor slots start at 0x4000 and are 32 bytes apart. A snoop write to byte address 0x4000 + 32*slot + 4*word sets the event flag of every enabled channel whose map matches that slot and word. Disabled channels and non-matching words raise nothing. The event mask reads back at 0x1094, and an event is presented on `req_o` in the cycle after the write.
- R5: A matching write to a channel whose event flag is already set sets that channel's missed bit. The missed mask reads back at 0x314, and writing a one there clears the bit.
- R6: Writing a one to 0x1094 clears that channel's event flag. Without such a write or an accept, the flag holds.
- R7: When several event flags are set, the lowest-numbered channel is presented on `req_ch_o` together with its slot on `req_slot_o`. `req_ack_i` clears the flag of the presented channel.
- R8: A snoop write to word 0 of a channel's mapped slot captures the completion code from bits 17:12 of the written data and the completion-interrupt enable from bit 20.
- R9: `done_i` with channel `done_ch_i` sets pending bit n, where n is that channel's captured code, but only if its interrupt enable is set. Bits 0..31 read at 0x1068 and bits 32..63 read at 0x106C.
- R10: Writing ones to 0x1070 clears the low pending bits, and writing ones to 0x1074 clears the high pending bits. Zero bits change nothing. `irq_o` is high exactly when any pending bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 16 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| dsc_wr_i | input | 1 | Snooped descriptor write strobe |
| dsc_addr_i | input | 16 | Snooped descriptor byte address |
| dsc_wdata_i | input | 32 | Snooped descriptor write data |
| req_o | output | 1 | Transfer request to the engine |
| req_ch_o | output | 3 | Channel being requested |
| req_slot_o | output | 9 | Slot of the requested channel |
| req_ack_i | input | 1 | Engine accepts the presented request |
| done_i | input | 1 | Engine reports a finished transfer |
| done_ch_i | input | 3 | Channel of the finished transfer |
| irq_o | output | 1 | OR of all pending bits |

## Verification
A corrupted map or enable register shows up one cycle after the next snoop write. The symptom is either a request that should not appear, or a missing one, on `req_o`. A wrong event or missed flag is visible at once through the read mux and through the request channel number. A stale captured code lands in the wrong half or bit of the pending space, so it is seen on the read after the next `done_i`. `irq_o` reflects the pending state with no delay.

// File: rtl/qtc_pkg.sv
package qtc_pkg;
  localparam int NCH      = 8;
  localparam int SLOT_W   = 9;
  localparam int WORD_W   = 3;
  localparam int CODE_W   = 6;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 32;

  localparam int OPT_CODE_LSB = 12;
  localparam int OPT_IEN_BIT  = 20;

  localparam logic [15:0] OFS_MAP      = 16'h0200;
  localparam logic [15:0] OFS_MISS_CLR = 16'h0314;
  localparam logic [15:0] OFS_PEND_LO  = 16'h1068;
  localparam logic [15:0] OFS_PEND_HI  = 16'h106C;
  localparam logic [15:0] OFS_PCLR_LO  = 16'h1070;
  localparam logic [15:0] OFS_PCLR_HI  = 16'h1074;
  localparam logic [15:0] OFS_EN_CLR   = 16'h1088;
  localparam logic [15:0] OFS_EN_SET   = 16'h108C;
  localparam logic [15:0] OFS_EV_CLR   = 16'h1094;
  localparam logic [15:0] DSC_BASE     = 16'h4000;
endpackage

// File: rtl/qtc_chan_slice.sv
module qtc_chan_slice
  import qtc_pkg::*;
#(
  parameter int SLOT_W = qtc_pkg::SLOT_W,
  parameter int WORD_W = qtc_pkg::WORD_W,
  parameter int CODE_W = qtc_pkg::CODE_W,
  parameter int ADDR_W = qtc_pkg::ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              map_we_i,
  input  logic [SLOT_W-1:0] map_slot_i,
  input  logic [WORD_W-1:0] map_word_i,
  input  logic              dsc_wr_i,
  input  logic [ADDR_W-3:0] dsc_waddr_i,  // word address
  input  logic [CODE_W-1:0] opt_code_i,
  input  logic              opt_ien_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [WORD_W-1:0] word_o,
  output logic              hit_o,
  output logic [CODE_W-1:0] code_o,
  output logic              ien_o
);
  localparam int REG_LSB = SLOT_W + WORD_W;

  logic [SLOT_W-1:0] slot_q;
  logic [WORD_W-1:0] word_q;
  logic [CODE_W-1:0] code_q;
  logic              ien_q;
  logic              in_region, slot_hit, opt_wr;

  assign in_region = dsc_waddr_i[ADDR_W-3:REG_LSB] == DSC_BASE[ADDR_W-1:REG_LSB+2];
  assign slot_hit  = dsc_wr_i && in_region && (dsc_waddr_i[WORD_W +: SLOT_W] == slot_q);
  assign hit_o     = slot_hit && (dsc_waddr_i[WORD_W-1:0] == word_q);
  assign opt_wr    = slot_hit && (dsc_waddr_i[WORD_W-1:0] == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      word_q <= '0;
      code_q <= '0;
      ien_q  <= 1'b0;
    end else begin
      if (map_we_i) begin
        slot_q <= map_slot_i;
        word_q <= map_word_i;
      end
      if (opt_wr) begin
        code_q <= opt_code_i;
        ien_q  <= opt_ien_i;
      end
    end
  end

  assign slot_o = slot_q;
  assign word_o = word_q;
  assign code_o = code_q;
  assign ien_o  = ien_q;
endmodule

// File: rtl/qtc_prio_pick.sv
module qtc_prio_pick #(
  parameter int N    = 8,
  localparam int IW  = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/qtc_pend_bank.sv
module qtc_pend_bank #(
  parameter int CODE_W  = 6,
  parameter int DATA_W  = 32,
  localparam int PEND_W = 1 << CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [CODE_W-1:0] set_idx_i,
  input  logic              clr_lo_i,
  input  logic              clr_hi_i,
  input  logic [DATA_W-1:0] clr_data_i,
  output logic [PEND_W-1:0] pend_o
);
  logic [PEND_W-1:0] pend_q, set_mask, clr_mask;

  always_comb begin
    set_mask = '0;
    if (set_i) set_mask[set_idx_i] = 1'b1;
    clr_mask = '0;
    if (clr_lo_i) clr_mask[DATA_W-1:0]      = clr_data_i;
    if (clr_hi_i) clr_mask[PEND_W-1:DATA_W] = clr_data_i;
  end

  // a new completion wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_mask) | set_mask;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/qtc_ctrl.sv
module qtc_ctrl
  import qtc_pkg::*;
#(
  parameter int NCH    = qtc_pkg::NCH,
  parameter int SLOT_W = qtc_pkg::SLOT_W,
  parameter int WORD_W = qtc_pkg::WORD_W,
  parameter int CODE_W = qtc_pkg::CODE_W,
  parameter int ADDR_W = qtc_pkg::ADDR_W,
  parameter int DATA_W = qtc_pkg::DATA_W,
  localparam int CH_W   = $clog2(NCH),
  localparam int PEND_W = 1 << CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              dsc_wr_i,
  input  logic [ADDR_W-1:0] dsc_addr_i,
  input  logic [DATA_W-1:0] dsc_wdata_i,
  output logic              req_o,
  output logic [CH_W-1:0]   req_ch_o,
  output logic [SLOT_W-1:0] req_slot_o,
  input  logic              req_ack_i,
  input  logic              done_i,
  input  logic [CH_W-1:0]   done_ch_i,
  output logic              irq_o
);
  logic [NCH-1:0]    en_q, ev_q, miss_q;
  logic [NCH-1:0]    hit, trig, ack_mask, map_we;
  logic [SLOT_W-1:0] slot_a [NCH];
  logic [WORD_W-1:0] word_a [NCH];
  logic [CODE_W-1:0] code_a [NCH];
  logic [NCH-1:0]    ien_a;
  logic [PEND_W-1:0] pend_q;
  logic              map_sel, unused_snoop;
  logic [CH_W-1:0]   map_idx;

  assign map_sel = reg_addr_i[ADDR_W-1:CH_W+2] == OFS_MAP[ADDR_W-1:CH_W+2];
  assign map_idx = reg_addr_i[CH_W+1:2];
  assign unused_snoop = ^dsc_addr_i[1:0];

  function automatic logic wr_at(input logic [ADDR_W-1:0] ofs);
    return reg_wr_i && (reg_addr_i == ofs);
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign map_we[c] = reg_wr_i && map_sel && (map_idx == CH_W'(c));
    qtc_chan_slice #(
      .SLOT_W(SLOT_W), .WORD_W(WORD_W), .CODE_W(CODE_W), .ADDR_W(ADDR_W)
    ) slice_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .map_we_i   (map_we[c]),
      .map_slot_i (reg_wdata_i[WORD_W+2 +: SLOT_W]),
      .map_word_i (reg_wdata_i[2 +: WORD_W]),
      .dsc_wr_i   (dsc_wr_i),
      .dsc_waddr_i(dsc_addr_i[ADDR_W-1:2]),
      .opt_code_i (dsc_wdata_i[OPT_CODE_LSB +: CODE_W]),
      .opt_ien_i  (dsc_wdata_i[OPT_IEN_BIT]),
      .slot_o     (slot_a[c]),
      .word_o     (word_a[c]),
      .hit_o      (hit[c]),
      .code_o     (code_a[c]),
      .ien_o      (ien_a[c])
    );
  end

  assign trig = hit & en_q;

  qtc_prio_pick #(.N(NCH)) pick_i (
    .vec_i(ev_q),
    .any_o(req_o),
    .idx_o(req_ch_o)
  );
  assign req_slot_o = slot_a[req_ch_o];

  always_comb begin
    ack_mask = '0;
    if (req_ack_i && req_o) ack_mask[req_ch_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      ev_q   <= '0;
      miss_q <= '0;
    end else begin
      en_q   <= (en_q & ~(wr_at(OFS_EN_CLR) ? reg_wdata_i[NCH-1:0] : '0))
              | (wr_at(OFS_EN_SET) ? reg_wdata_i[NCH-1:0] : '0);
      ev_q   <= (ev_q & ~ack_mask & ~(wr_at(OFS_EV_CLR) ? reg_wdata_i[NCH-1:0] : '0))
              | trig;
      miss_q <= (miss_q & ~(wr_at(OFS_MISS_CLR) ? reg_wdata_i[NCH-1:0] : '0))
              | (trig & ev_q);
    end
  end

  qtc_pend_bank #(.CODE_W(CODE_W), .DATA_W(DATA_W)) pend_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (done_i && ien_a[done_ch_i]),
    .set_idx_i (code_a[done_ch_i]),
    .clr_lo_i  (wr_at(OFS_PCLR_LO)),
    .clr_hi_i  (wr_at(OFS_PCLR_HI)),
    .clr_data_i(reg_wdata_i),
    .pend_o    (pend_q)
  );
  assign irq_o = |pend_q;

  always_comb begin
    reg_rdata_o = '0;
    if (map_sel)
      reg_rdata_o[2 +: SLOT_W+WORD_W] = {slot_a[map_idx], word_a[map_idx]};
    else if (reg_addr_i == OFS_EN_SET)   reg_rdata_o[NCH-1:0] = en_q;
    else if (reg_addr_i == OFS_EV_CLR)   reg_rdata_o[NCH-1:0] = ev_q;
    else if (reg_addr_i == OFS_MISS_CLR) reg_rdata_o[NCH-1:0] = miss_q;
    else if (reg_addr_i == OFS_PEND_LO)  reg_rdata_o = pend_q[DATA_W-1:0];
    else if (reg_addr_i == OFS_PEND_HI)  reg_rdata_o = pend_q[PEND_W-1:DATA_W];
  end
endmodule

// File: rtl/qtc_ctrl_chk.sv
module qtc_ctrl_chk
  import qtc_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int PEND_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              dsc_wr_i,
  input logic              req_o,
  input logic              req_ack_i,
  input logic              done_i,
  input logic              irq_o,
  input logic [NCH-1:0]    miss_i,
  input logic [PEND_W-1:0] pend_i
);
  AST_EVT_FROM_SNOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(dsc_wr_i)); // R4

  AST_MISS_NEEDS_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(miss_i & ~$past(miss_i))) |-> $past(dsc_wr_i && req_o)); // R5

  AST_EVT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !req_ack_i && !(reg_wr_i && reg_addr_i == OFS_EV_CLR)) |=> req_o); // R6

  AST_IRQ_FROM_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(done_i)); // R9

  AST_PEND_LO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == OFS_PCLR_LO && (&reg_wdata_i) && !done_i)
      |=> (pend_i[DATA_W-1:0] == '0)); // R10
endmodule

bind qtc_ctrl qtc_ctrl_chk #(
  .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PEND_W(PEND_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .dsc_wr_i   (dsc_wr_i),
  .req_o      (req_o),
  .req_ack_i  (req_ack_i),
  .done_i     (done_i),
  .irq_o      (irq_o),
  .miss_i     (miss_q),
  .pend_i     (pend_q)
);

// File: tb/qtc_ctrl_tb_top.sv
module qtc_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dsc_wr = 1'b0;
  logic [15:0] dsc_addr = '0;
  logic [31:0] dsc_wdata = '0;
  logic        req;
  logic [2:0]  req_ch;
  logic [8:0]  req_slot;
  logic        req_ack = 1'b0;
  logic        done = 1'b0;
  logic [2:0]  done_ch = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qtc_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .dsc_wr_i(dsc_wr), .dsc_addr_i(dsc_addr), .dsc_wdata_i(dsc_wdata),
    .req_o(req), .req_ch_o(req_ch), .req_slot_o(req_slot), .req_ack_i(req_ack),
    .done_i(done), .done_ch_i(done_ch), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic snoop(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); dsc_wr = 1'b1; dsc_addr = a; dsc_wdata = d;
    @(negedge clk); dsc_wr = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); req_ack = 1'b1;
    @(negedge clk); req_ack = 1'b0;
  endtask

  task automatic finish_ch(input logic [2:0] c);
    @(negedge clk); done = 1'b1; done_ch = c;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1 map0", 16'h0200, 0);
    rd_chk("R1 enable", 16'h108C, 0);
    rd_chk("R1 pend lo", 16'h1068, 0);
    rd_chk("R1 pend hi", 16'h106C, 0);
    chk("R1 req", 32'(req), 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_map();
    wr(16'h0204, 32'hFFFF_FFFF);
    rd_chk("R2 map1 all ones", 16'h0204, 32'h0000_3FFC);
    wr(16'h020C, (32'd5 << 5) | (32'd7 << 2));
    rd_chk("R2 map3", 16'h020C, 32'h0000_00BC);
    rd_chk("R2 map2 untouched", 16'h0208, 0);
  endtask

  task automatic t_enable();
    wr(16'h108C, 32'h0A);
    rd_chk("R3 set", 16'h108C, 32'h0A);
    wr(16'h1088, 32'h02);
    rd_chk("R3 clear", 16'h108C, 32'h08);
    wr(16'h108C, 32'h00);
    rd_chk("R3 zero write", 16'h108C, 32'h08);
    wr(16'h1088, 32'hFF);
    rd_chk("R3 clear all", 16'h108C, 0);
  endtask

  task automatic t_trigger();
    wr(16'h0208, (32'd10 << 5) | (32'd3 << 2));
    snoop(16'h414C, 0);
    chk("R4 disabled no req", 32'(req), 0);
    wr(16'h108C, 32'h04);
    snoop(16'h4148, 0);
    chk("R4 other word no req", 32'(req), 0);
    snoop(16'h414C, 0);
    chk("R4 req", 32'(req), 1);
    chk("R4 req ch", 32'(req_ch), 2);
    chk("R4 req slot", 32'(req_slot), 10);
    rd_chk("R4 event mask", 16'h1094, 32'h04);
  endtask

  task automatic t_missed();
    snoop(16'h414C, 0);
    rd_chk("R5 missed set", 16'h0314, 32'h04);
    wr(16'h0314, 32'h04);
    rd_chk("R5 missed cleared", 16'h0314, 0);
  endtask

  task automatic t_evclr();
    wr(16'h1094, 32'h04);
    rd_chk("R6 event cleared", 16'h1094, 0);
    chk("R6 req dropped", 32'(req), 0);
  endtask

  task automatic t_priority();
    wr(16'h0218, (32'd3 << 5) | (32'd1 << 2));
    wr(16'h0214, (32'd3 << 5) | (32'd1 << 2));
    wr(16'h108C, 32'h60);
    snoop(16'h4064, 0);
    chk("R7 lowest first", 32'(req_ch), 5);
    chk("R7 slot", 32'(req_slot), 3);
    ack();
    chk("R7 next ch", 32'(req_ch), 6);
    chk("R7 still req", 32'(req), 1);
    ack();
    chk("R7 all served", 32'(req), 0);
  endtask

  task automatic t_complete();
    snoop(16'h4060, (32'd1 << 20) | (32'd40 << 12));
    chk("R8 word0 no req", 32'(req), 0);
    finish_ch(3'd5);
    rd_chk("R8 R9 pend hi", 16'h106C, 32'h100);
    rd_chk("R9 pend lo", 16'h1068, 0);
    chk("R10 irq", 32'(irq), 1);
    snoop(16'h4140, 32'd3 << 12);
    finish_ch(3'd2);
    rd_chk("R9 no ien", 16'h1068, 0);
    snoop(16'h4140, (32'd1 << 20) | (32'd3 << 12));
    finish_ch(3'd2);
    rd_chk("R8 R9 pend lo", 16'h1068, 32'h8);
  endtask

  task automatic t_clear();
    wr(16'h1074, 32'h0);
    rd_chk("R10 zero clear", 16'h106C, 32'h100);
    wr(16'h1070, 32'h8);
    rd_chk("R10 lo cleared", 16'h1068, 0);
    chk("R10 irq hi left", 32'(irq), 1);
    wr(16'h1074, 32'h100);
    rd_chk("R10 hi cleared", 16'h106C, 0);
    chk("R10 irq low", 32'(irq), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_enable();
    t_trigger();
    t_missed();
    t_evclr();
    t_priority();
    t_complete();
    t_clear();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule